// File: doc/BRIEF.md
# Thermistor Temperature Zone Controller

This block watches a battery pack thermistor and turns its temperature into charge-control decisions. It drives a bias enable for the thermistor sense node. The bias is on for a short window at the start of each repeating period whenever the input supply is present, and it has no software control that could keep it off while that supply is up. Digitised sense codes come back on a valid-qualified input. Each accepted code is compared against four programmable thresholds and sorted into one of five zones. Because the sense voltage falls as temperature rises, a high code means cold and a low code means hot.

From the stored zone and the selected mode, the block drives four charge controls: a suspend flag, a timer-hold flag, a fast-charge current code and a reduced-regulation select. In the cool zone the current code is scaled down, and the result is truncated to whole steps. Entering the hot or cold zone counts as a temperature fault in every mode. A fault fires one fixed-length interrupt pulse and sets a sticky status bit. Status bits are cleared by a read strobe, and a fault that arrives in the same cycle as a read survives that read. All intervals are whole numbers of prescaled ticks, so they can be shortened by parameters.

Top module: `therm_zone_ctrl`

## Requirements
- R1: With `vin_present` high, `bias_en` is high for BIAS_ON_TICKS×TICK_DIV cycles and then low for (BIAS_PERIOD_TICKS−BIAS_ON_TICKS)×TICK_DIV cycles, and this repeats. The first window starts in the cycle `vin_present` rises. With `vin_present` low, `bias_en` is low.
- R2: An accepted code is classified as follows: code > `thr_cold` gives COLD (1); otherwise code > `thr_cool` gives COOL (2); otherwise code < `thr_hot` gives HOT (4); otherwise code < `thr_warm` gives WARM (3); otherwise NORMAL (0). Threshold order is cold > cool > warm > hot.
- R3: `zone` changes only on the clock edge that samples `sample_valid` high, is visible from the next cycle, and holds its value between samples. After reset it is NORMAL.
- R4: With `mode` = 2 (four-zone), HOT or COLD drives both `charge_suspend` and `timer_hold` high. Otherwise both are low.
- R5: With `mode` = 2 and zone COOL, `ichg_eff` = floor(`ichg_code` × (8 − `cool_scale`) / 8). Scale 7 therefore gives one eighth, and scale 0 gives the full code. In every other case `ichg_eff` equals `ichg_code`.
- R6: With `mode` = 2 and zone WARM, `vreg_reduced` is high. Otherwise it is low.
- R7: With `mode` = 1 (hot/cold only), HOT or COLD drives `charge_suspend` and `timer_hold` high. The COOL and WARM zones leave `ichg_eff` and `vreg_reduced` unchanged.
- R8: With `mode` = 0 or 3 (disabled), `charge_suspend`, `timer_hold` and `vreg_reduced` stay low and `ichg_eff` equals `ichg_code`. The zone is still classified.
- R9: In every mode, an accepted code whose zone is HOT or COLD, when the stored zone differs, starts one `int_pulse` that is high for exactly INT_TICKS×TICK_DIV cycles. It starts two edges after the sample. A repeat sample in the same zone starts no pulse.
- R10: Fault status bit 0 (hot entry) and bit 1 (cold entry) set together with the start of the pulse. They stay set until a cycle with `status_rd` high, and the following cycle they read zero.
- R11: A fault that sets a status bit on the same edge that samples `status_rd` leaves that bit set after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_present | input | 1 | Input supply present |
| bias_en | output | 1 | Thermistor bias enable |
| sample_valid | input | 1 | Sense code strobe |
| sample_code | input | ADC_W | Digitised sense voltage |
| thr_cold | input | ADC_W | Cold threshold (highest) |
| thr_cool | input | ADC_W | Cool threshold |
| thr_warm | input | ADC_W | Warm threshold |
| thr_hot | input | ADC_W | Hot threshold (lowest) |
| mode | input | 2 | 0/3 disabled, 1 hot/cold only, 2 four-zone |
| ichg_code | input | ICHG_W | Programmed fast-charge code in LSB steps |
| cool_scale | input | 3 | Cool-zone current scale code |
| zone | output | 3 | Stored zone |
| charge_suspend | output | 1 | Suspend charging |
| timer_hold | output | 1 | Hold charge and safety timers |
| ichg_eff | output | ICHG_W | Effective fast-charge code |
| vreg_reduced | output | 1 | Select reduced regulation voltage |
| int_pulse | output | 1 | Fault interrupt pulse |
| status_rd | input | 1 | Status read strobe, clears on read |
| fault_status | output | 2 | Sticky faults: bit0 hot, bit1 cold |

## Verification
The hardest case to reach is a fault that sets a status bit on the same edge at which a read clears the others. That edge comes two cycles after the sample, so the bench first makes the status non-zero by entering COLD. It then returns to NORMAL, presents a HOT sample, and raises the read strobe in the cycle after the sample strobe. It expects the cold bit gone and the hot bit kept. The exact pulse and bias lengths are measured by counting cycles, with short tick parameters.

// File: rtl/therm_zone_pkg.sv
package therm_zone_pkg;

    typedef enum logic [2:0] {
        ZN_NORMAL = 3'd0,
        ZN_COLD   = 3'd1,
        ZN_COOL   = 3'd2,
        ZN_WARM   = 3'd3,
        ZN_HOT    = 3'd4
    } zone_e;

    typedef enum logic [1:0] {
        MD_OFF     = 2'd0,
        MD_EXTREME = 2'd1,
        MD_FULL    = 2'd2,
        MD_RSVD    = 2'd3
    } mode_e;

    localparam int FLT_W    = 2;
    localparam int FLT_HOT  = 0;
    localparam int FLT_COLD = 1;

endpackage

// File: rtl/tz_tick.sv
module tz_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/tz_bias_seq.sv
module tz_bias_seq #(
    parameter int TICK_DIV     = 100,
    parameter int ON_TICKS     = 25000,
    parameter int PERIOD_TICKS = 225000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin_present,
    output logic bias_en
);
    localparam int PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(PERIOD_TICKS - 1);
    localparam logic [PW-1:0] P_ON   = PW'(ON_TICKS);

    logic          tick;
    logic [PW-1:0] per_d, per_q;

    tz_tick #(.DIV(TICK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!vin_present),
        .tick  (tick)
    );

    always_comb begin
        per_d = per_q;
        if (!vin_present)     per_d = '0;
        else if (tick)        per_d = (per_q == P_LAST) ? '0 : per_q + 1'b1;
        bias_en = vin_present && (per_q < P_ON);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) per_q <= '0;
        else        per_q <= per_d;
    end

    // R1
    bias_needs_vin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bias_en |-> vin_present);

    // R1
    window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_present |=> per_q == '0);

endmodule

// File: rtl/tz_zone_eval.sv
module tz_zone_eval
    import therm_zone_pkg::*;
#(
    parameter int ADC_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_valid,
    input  logic [ADC_W-1:0]     sample_code,
    input  logic [ADC_W-1:0]     thr_cold,
    input  logic [ADC_W-1:0]     thr_cool,
    input  logic [ADC_W-1:0]     thr_warm,
    input  logic [ADC_W-1:0]     thr_hot,
    output zone_e                zone,
    output logic [FLT_W-1:0]     fault_evt
);
    typedef struct packed {
        zone_e             zone;
        logic [FLT_W-1:0]  evt;
    } ev_st_t;

    ev_st_t st_d, st_q;
    zone_e  cls;

    always_comb begin
        if (sample_code > thr_cold)      cls = ZN_COLD;
        else if (sample_code > thr_cool) cls = ZN_COOL;
        else if (sample_code < thr_hot)  cls = ZN_HOT;
        else if (sample_code < thr_warm) cls = ZN_WARM;
        else                             cls = ZN_NORMAL;

        st_d.zone = st_q.zone;
        st_d.evt  = '0;
        if (sample_valid) begin
            st_d.zone = cls;
            if (cls == ZN_HOT  && st_q.zone != ZN_HOT)  st_d.evt[FLT_HOT]  = 1'b1;
            if (cls == ZN_COLD && st_q.zone != ZN_COLD) st_d.evt[FLT_COLD] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.zone <= ZN_NORMAL;
            st_q.evt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign zone      = st_q.zone;
    assign fault_evt = st_q.evt;

    // R3
    zone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(st_q.zone));

    // R2
    cold_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && sample_code > thr_cold) |=> st_q.zone == ZN_COLD);

    // R9
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.evt));

endmodule

// File: rtl/tz_charge_ctl.sv
module tz_charge_ctl
    import therm_zone_pkg::*;
#(
    parameter int ICHG_W = 8
) (
    input  logic [1:0]         mode,
    input  zone_e              zone,
    input  logic [ICHG_W-1:0]  ichg_code,
    input  logic [2:0]         cool_scale,
    output logic               charge_suspend,
    output logic               timer_hold,
    output logic [ICHG_W-1:0]  ichg_eff,
    output logic               vreg_reduced
);
    localparam int PRW = ICHG_W + 4;

    mode_e            md;
    logic             extreme;
    logic [3:0]       mult;
    logic [PRW-1:0]   prod;
    logic [ICHG_W-1:0] scaled;

    always_comb begin
        md      = mode_e'(mode);
        extreme = (zone == ZN_HOT) || (zone == ZN_COLD);
        mult    = 4'd8 - {1'b0, cool_scale};
        prod    = PRW'(ichg_code) * PRW'(mult);
        scaled  = prod[ICHG_W+2:3];

        charge_suspend = 1'b0;
        timer_hold     = 1'b0;
        ichg_eff       = ichg_code;
        vreg_reduced   = 1'b0;
        case (md)
            MD_FULL: begin
                charge_suspend = extreme;
                timer_hold     = extreme;
                if (zone == ZN_COOL) ichg_eff = scaled;
                vreg_reduced   = (zone == ZN_WARM);
            end
            MD_EXTREME: begin
                charge_suspend = extreme;
                timer_hold     = extreme;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tz_fault_unit.sv
module tz_fault_unit
    import therm_zone_pkg::*;
#(
    parameter int TICK_DIV  = 100,
    parameter int INT_TICKS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLT_W-1:0]  fault_evt,
    input  logic              status_rd,
    output logic              int_pulse,
    output logic [FLT_W-1:0]  fault_status
);
    localparam int IW = $clog2(INT_TICKS + 1);

    typedef struct packed {
        logic [IW-1:0]    cnt;
        logic [FLT_W-1:0] stat;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic    tick;
    logic    any_evt;

    assign any_evt = |fault_evt;

    tz_tick #(.DIV(TICK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (any_evt),
        .tick  (tick)
    );

    always_comb begin
        st_d = st_q;
        if (any_evt)                      st_d.cnt = IW'(INT_TICKS);
        else if (tick && st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
        st_d.stat = (status_rd ? '0 : st_q.stat) | fault_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign int_pulse    = (st_q.cnt != '0);
    assign fault_status = st_q.stat;

    // R9
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_pulse) |-> $past(any_evt));

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rd |=> (($past(st_q.stat) & ~st_q.stat) == '0));

    // R11
    rd_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && any_evt) |=> ((st_q.stat & $past(fault_evt)) == $past(fault_evt)));

endmodule

// File: rtl/therm_zone_ctrl.sv
module therm_zone_ctrl
    import therm_zone_pkg::*;
#(
    parameter int ADC_W             = 10,
    parameter int ICHG_W            = 8,
    parameter int TICK_DIV          = 100,
    parameter int BIAS_ON_TICKS     = 25000,
    parameter int BIAS_PERIOD_TICKS = 225000,
    parameter int INT_TICKS         = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vin_present,
    output logic              bias_en,
    input  logic              sample_valid,
    input  logic [ADC_W-1:0]  sample_code,
    input  logic [ADC_W-1:0]  thr_cold,
    input  logic [ADC_W-1:0]  thr_cool,
    input  logic [ADC_W-1:0]  thr_warm,
    input  logic [ADC_W-1:0]  thr_hot,
    input  logic [1:0]        mode,
    input  logic [ICHG_W-1:0] ichg_code,
    input  logic [2:0]        cool_scale,
    output logic [2:0]        zone,
    output logic              charge_suspend,
    output logic              timer_hold,
    output logic [ICHG_W-1:0] ichg_eff,
    output logic              vreg_reduced,
    output logic              int_pulse,
    input  logic              status_rd,
    output logic [1:0]        fault_status
);
    zone_e             zone_w;
    logic [FLT_W-1:0]  evt_w;

    tz_bias_seq #(
        .TICK_DIV     (TICK_DIV),
        .ON_TICKS     (BIAS_ON_TICKS),
        .PERIOD_TICKS (BIAS_PERIOD_TICKS)
    ) bias_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .vin_present (vin_present),
        .bias_en     (bias_en)
    );

    tz_zone_eval #(.ADC_W(ADC_W)) eval_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_code  (sample_code),
        .thr_cold     (thr_cold),
        .thr_cool     (thr_cool),
        .thr_warm     (thr_warm),
        .thr_hot      (thr_hot),
        .zone         (zone_w),
        .fault_evt    (evt_w)
    );

    tz_charge_ctl #(.ICHG_W(ICHG_W)) chg_i (
        .mode           (mode),
        .zone           (zone_w),
        .ichg_code      (ichg_code),
        .cool_scale     (cool_scale),
        .charge_suspend (charge_suspend),
        .timer_hold     (timer_hold),
        .ichg_eff       (ichg_eff),
        .vreg_reduced   (vreg_reduced)
    );

    tz_fault_unit #(
        .TICK_DIV  (TICK_DIV),
        .INT_TICKS (INT_TICKS)
    ) flt_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_evt    (evt_w),
        .status_rd    (status_rd),
        .int_pulse    (int_pulse),
        .fault_status (fault_status)
    );

    assign zone = zone_w;

    // R8
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_OFF || mode == MD_RSVD) |-> (!charge_suspend && !timer_hold && !vreg_reduced));

    // R4
    suspend_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        charge_suspend |-> (zone_w == ZN_HOT || zone_w == ZN_COLD));

endmodule

// File: tb/therm_zone_ctrl_tb_top.sv
`timescale 1ns/1ps
module therm_zone_ctrl_tb_top;

    localparam int ADC_W = 8;
    localparam int ICHG_W = 8;
    localparam int DIV = 2;
    localparam int ON_T = 5;
    localparam int PER_T = 20;
    localparam int INT_T = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin_present = 1'b0;
    logic bias_en;
    logic sample_valid = 1'b0;
    logic [ADC_W-1:0] sample_code = '0;
    logic [ADC_W-1:0] thr_cold = 8'd200, thr_cool = 8'd150, thr_warm = 8'd100, thr_hot = 8'd50;
    logic [1:0] mode = 2'd2;
    logic [ICHG_W-1:0] ichg_code = 8'd12;
    logic [2:0] cool_scale = 3'd7;
    logic [2:0] zone;
    logic charge_suspend, timer_hold, vreg_reduced, int_pulse;
    logic [ICHG_W-1:0] ichg_eff;
    logic status_rd = 1'b0;
    logic [1:0] fault_status;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    therm_zone_ctrl #(
        .ADC_W(ADC_W), .ICHG_W(ICHG_W), .TICK_DIV(DIV),
        .BIAS_ON_TICKS(ON_T), .BIAS_PERIOD_TICKS(PER_T), .INT_TICKS(INT_T)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .vin_present(vin_present), .bias_en(bias_en),
        .sample_valid(sample_valid), .sample_code(sample_code),
        .thr_cold(thr_cold), .thr_cool(thr_cool), .thr_warm(thr_warm), .thr_hot(thr_hot),
        .mode(mode), .ichg_code(ichg_code), .cool_scale(cool_scale),
        .zone(zone), .charge_suspend(charge_suspend), .timer_hold(timer_hold),
        .ichg_eff(ichg_eff), .vreg_reduced(vreg_reduced), .int_pulse(int_pulse),
        .status_rd(status_rd), .fault_status(fault_status)
    );

    typedef struct packed {
        logic [1:0] md;
        logic [7:0] code;
        logic [2:0] zn;
        logic       susp;
        logic       hold;
        logic [7:0] ich;
        logic       vr;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 8'd201, 3'd1, 1'b1, 1'b1, 8'd12, 1'b0},
        '{2'd2, 8'd255, 3'd1, 1'b1, 1'b1, 8'd12, 1'b0},
        '{2'd2, 8'd200, 3'd2, 1'b0, 1'b0, 8'd1,  1'b0},
        '{2'd2, 8'd151, 3'd2, 1'b0, 1'b0, 8'd1,  1'b0},
        '{2'd2, 8'd150, 3'd0, 1'b0, 1'b0, 8'd12, 1'b0},
        '{2'd2, 8'd100, 3'd0, 1'b0, 1'b0, 8'd12, 1'b0},
        '{2'd2, 8'd99,  3'd3, 1'b0, 1'b0, 8'd12, 1'b1},
        '{2'd2, 8'd50,  3'd3, 1'b0, 1'b0, 8'd12, 1'b1},
        '{2'd2, 8'd49,  3'd4, 1'b1, 1'b1, 8'd12, 1'b0},
        '{2'd2, 8'd0,   3'd4, 1'b1, 1'b1, 8'd12, 1'b0},
        '{2'd1, 8'd175, 3'd2, 1'b0, 1'b0, 8'd12, 1'b0},
        '{2'd1, 8'd75,  3'd3, 1'b0, 1'b0, 8'd12, 1'b0},
        '{2'd1, 8'd30,  3'd4, 1'b1, 1'b1, 8'd12, 1'b0},
        '{2'd0, 8'd30,  3'd4, 1'b0, 1'b0, 8'd12, 1'b0},
        '{2'd0, 8'd220, 3'd1, 1'b0, 1'b0, 8'd12, 1'b0},
        '{2'd3, 8'd99,  3'd3, 1'b0, 1'b0, 8'd12, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic take(input logic [7:0] code);
        @(negedge clk);
        sample_code  = code;
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic read_status();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R3, R10, R1)
        chk("R3 reset zone", zone, 0);
        chk("R10 reset status", fault_status, 0);
        chk("R9 reset int", int_pulse, 0);
        chk("R1 bias without vin", bias_en, 0);

        // Table walk: R2, R4, R5, R6, R7, R8
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode = VECS[i].md;
            take(VECS[i].code);
            chk("R2 zone", zone, VECS[i].zn);
            chk("R4/R7 suspend", charge_suspend, VECS[i].susp);
            chk("R4/R7 hold", timer_hold, VECS[i].hold);
            chk("R5 current", ichg_eff, VECS[i].ich);
            chk("R6 vreg", vreg_reduced, VECS[i].vr);
            // R8 covered by disabled rows
        end

        // R3: zone holds with no strobe while code changes
        sample_code = 8'd10;
        repeat (4) @(negedge clk);
        chk("R3 hold between samples", zone, 3);

        // R5 second scale: 12*5/8 = 7.5 -> 7
        mode = 2'd2;
        cool_scale = 3'd3;
        take(8'd180);
        chk("R5 round down", ichg_eff, 7);
        cool_scale = 3'd0;
        #1 chk("R5 scale zero full", ichg_eff, 12);
        cool_scale = 3'd7;

        // R9/R10 pulse length in disabled mode
        mode = 2'd0;
        take(8'd128);
        repeat (20) @(negedge clk);
        read_status();
        chk("R10 cleared by read", fault_status, 0);
        take(8'd20);
        chk("R9 no pulse before second edge", int_pulse, 0);
        @(negedge clk);
        n = 0;
        while (int_pulse && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R9 pulse length", n, INT_T * DIV);
        chk("R10 hot bit set", fault_status, 1);
        take(8'd10);
        repeat (3) @(negedge clk);
        chk("R9 repeat sample no pulse", int_pulse, 0);
        chk("R10 sticky until read", fault_status, 1);
        read_status();
        chk("R10 clear on read", fault_status, 0);

        // R11: fault lands on read edge
        take(8'd240);
        repeat (12) @(negedge clk);
        chk("R10 cold bit set", fault_status, 2);
        take(8'd128);
        @(negedge clk);
        sample_code  = 8'd20;
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        status_rd    = 1'b1;
        @(negedge clk);
        status_rd    = 1'b0;
        chk("R11 fault survives read", fault_status, 1);

        // R1 bias timing
        repeat (12) @(negedge clk);
        vin_present = 1'b1;
        #1;
        n = 0;
        while (bias_en && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R1 bias high length", n, ON_T * DIV);
        n = 0;
        while (!bias_en && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R1 bias low length", n, (PER_T - ON_T) * DIV);
        vin_present = 1'b0;
        #1 chk("R1 bias off without vin", bias_en, 0);

        finish_run();
    end

endmodule